// File: doc/BRIEF.md
# Host Command Packet Writer

This block turns one host command message into the 32-bit words that a display serial link transmitter pulls from its FIFOs. A message starts with a descriptor that holds a 2-bit virtual channel, a 6-bit data type, a payload length and three flags: low-power request, acknowledge request and read-expected. The payload bytes then arrive one per handshake on a byte stream. The first word written is the packet header. It carries the data type, the channel and the first two payload bytes. All later payload bytes are packed four to a word.

Small messages are written to the host FIFO. Messages too large for it go to the larger video FIFO, and messages too large for either are refused at the descriptor. Once the last word is written, the block holds the bus-turnaround and high-speed indications. It then waits for the transmitter to report that the packet has gone out. It reports completion with a byte count, or it raises a timeout error when the programmable cycle limit runs out first.

Top module: `host_cmd_packer`

## Requirements
- R1: The first word written for a message is the header: bits [5:0] hold the data type, bits [7:6] the virtual channel, bits [15:8] payload byte 0, bits [23:16] payload byte 1 and bits [31:24] zero. A byte the message lacks reads as zero. A message with no payload still writes its header.
- R2: Payload bytes from index 2 onward are packed four per word in index order, with the lowest index in bits [7:0]. The final word is padded with zero bytes. A message writes no other words.
- R3: A descriptor whose length exceeds 4×VIDEO_DEPTH bytes raises `err_nospc` in that cycle. The block writes no word and stays ready. A length of exactly 4×VIDEO_DEPTH is accepted.
- R4: When the length exceeds 4×HOST_DEPTH bytes, every word of the message goes out with `wr_video`=1. Otherwise every word goes out with `wr_video`=0. `wr_video` is held constant for the whole message.
- R5: `bta_req` is 1 for the message when the acknowledge request or the read-expected flag is set, and 0 otherwise.
- R6: `hs_mode` is 1 for the message unless the low-power request is set.
- R7: When `tx_done` arrives, `done` pulses in that same cycle. If no turnaround was requested, `done_count` equals 4 plus the payload length. If a turnaround was requested, it equals 0.
- R8: While the selected FIFO reports full, `byte_ready` is low and no word is written.
- R9: After the last word is written, `err_timeout` pulses in wait cycle number `tmo_cycles`−1, counting the first wait cycle as 0, provided `tx_done` has not arrived. If `tx_done` arrives in that same cycle, completion wins and no error is raised. `done` and `err_timeout` never occur together.
- R10: `msg_ready` is 1 only while no message is in progress. The block returns to ready in the cycle after `done`, `err_timeout` or `err_nospc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | Descriptor present |
| msg_ready | output | 1 | Block idle, descriptor taken |
| msg_vc | input | 2 | Virtual channel |
| msg_dtype | input | 6 | Data type |
| msg_lp | input | 1 | Low-power request |
| msg_ack | input | 1 | Acknowledge request |
| msg_rd | input | 1 | Read response expected |
| msg_len | input | LEN_W | Payload length in bytes |
| byte_valid | input | 1 | Payload byte present |
| byte_ready | output | 1 | Payload byte taken |
| byte_data | input | 8 | Payload byte |
| host_full | input | 1 | Host FIFO full |
| video_full | input | 1 | Video FIFO full |
| wr_valid | output | 1 | FIFO write strobe |
| wr_data | output | 32 | FIFO write word |
| wr_video | output | 1 | 1 selects the video FIFO |
| bta_req | output | 1 | Turnaround after the packet |
| hs_mode | output | 1 | High-speed transmission |
| tx_done | input | 1 | Transmitter reports packet sent |
| tmo_cycles | input | TMO_W | Wait limit in cycles |
| done | output | 1 | Completion pulse |
| done_count | output | LEN_W+1 | Completed byte count |
| err_nospc | output | 1 | Message too large, refused |
| err_timeout | output | 1 | Transmission wait expired |

## Verification
Completion and timeout can fall in the same cycle. This happens when `tx_done` arrives in exactly the last wait cycle the limit allows. The bench provokes it by raising `tx_done` at wait cycle `tmo_cycles`−1, and it expects `done` with the correct count and no `err_timeout`. The neighbouring run lets the same cycle pass without `tx_done` and expects the error there and not a cycle earlier. A second collision occurs when the FIFO-full stall lands in the middle of a partly packed word. The bench holds full for three cycles inside a message and then expects the word stream to be identical to an unstalled one.

// File: rtl/hcpw_pkg.sv
package hcpw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WAIT = 2'd2
  } hcpw_state_e;

  // Bit offset of payload byte idx inside the word it lands in.
  function automatic int unsigned lane_shift(input int unsigned idx);
    if (idx < 2) return 8 * (idx + 1);
    return 8 * ((idx - 2) % 4);
  endfunction

  // True when byte idx is the last byte of its word.
  function automatic logic closes_word(input int unsigned idx, input int unsigned len);
    if (idx + 1 == len) return 1'b1;
    if (idx == 1) return 1'b1;
    if (idx >= 2 && ((idx - 2) % 4) == 3) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] header_base(input logic [1:0] vc, input logic [5:0] dt);
    return {24'h0, vc, dt};
  endfunction

endpackage

// File: rtl/hcpw_admit.sv
module hcpw_admit #(
  parameter int HOST_DEPTH  = 64,
  parameter int VIDEO_DEPTH = 480,
  parameter int LEN_W       = 12
) (
  input  logic [LEN_W-1:0] len,
  input  logic             lp,
  input  logic             ack,
  input  logic             rd,
  output logic             too_long,
  output logic             use_video,
  output logic             want_bta,
  output logic             want_hs
);
  localparam int unsigned HOST_BYTES  = 4 * HOST_DEPTH;
  localparam int unsigned VIDEO_BYTES = 4 * VIDEO_DEPTH;

  always_comb begin
    too_long  = 32'(len) > VIDEO_BYTES;
    use_video = 32'(len) > HOST_BYTES;
    want_bta  = ack | rd;
    want_hs   = ~lp;
  end
endmodule

// File: rtl/hcpw_packer.sv
module hcpw_packer
  import hcpw_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       vc,
  input  logic [5:0]       dtype,
  input  logic [LEN_W-1:0] len,
  input  logic             fire,
  input  logic [7:0]       data,
  output logic [31:0]      word,
  output logic             close,
  output logic             last
);
  logic [LEN_W-1:0] idx;
  logic [31:0]      acc;
  logic [31:0]      placed;

  always_comb begin
    placed = acc | (32'(data) << lane_shift(32'(idx)));
    close  = closes_word(32'(idx), 32'(len));
    last   = (32'(idx) + 32'd1) == 32'(len);
    word   = fire ? placed : acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= '0;
    end else if (load) begin
      idx <= '0;
      acc <= header_base(vc, dtype);
    end else if (fire) begin
      idx <= idx + 1'b1;
      acc <= close ? 32'h0 : placed;
    end
  end
endmodule

// File: rtl/hcpw_txwait.sv
module hcpw_txwait #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             tx_done,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;

  assign expire = arm && !tx_done && ((32'(cnt) + 32'd1) >= 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!arm) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/host_cmd_packer.sv
module host_cmd_packer
  import hcpw_pkg::*;
#(
  parameter int HOST_DEPTH  = 64,
  parameter int VIDEO_DEPTH = 480,
  parameter int LEN_W       = 12,
  parameter int TMO_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [1:0]         msg_vc,
  input  logic [5:0]         msg_dtype,
  input  logic               msg_lp,
  input  logic               msg_ack,
  input  logic               msg_rd,
  input  logic [LEN_W-1:0]   msg_len,
  input  logic               byte_valid,
  output logic               byte_ready,
  input  logic [7:0]         byte_data,
  input  logic               host_full,
  input  logic               video_full,
  output logic               wr_valid,
  output logic [31:0]        wr_data,
  output logic               wr_video,
  output logic               bta_req,
  output logic               hs_mode,
  input  logic               tx_done,
  input  logic [TMO_W-1:0]   tmo_cycles,
  output logic               done,
  output logic [LEN_W:0]     done_count,
  output logic               err_nospc,
  output logic               err_timeout
);
  localparam int CNT_W = LEN_W + 1;

  hcpw_state_e      st;
  logic [LEN_W-1:0] len_q;
  logic             too_long, use_video, want_bta, want_hs;
  logic             accept, sel_full, hdr_only, byte_fire;
  logic             in_fill, in_wait, fill_end;
  logic             pk_close, pk_last, expire;
  logic [31:0]      pk_word;

  hcpw_admit #(.HOST_DEPTH(HOST_DEPTH), .VIDEO_DEPTH(VIDEO_DEPTH), .LEN_W(LEN_W)) u_admit (
    .len(msg_len), .lp(msg_lp), .ack(msg_ack), .rd(msg_rd),
    .too_long(too_long), .use_video(use_video), .want_bta(want_bta), .want_hs(want_hs)
  );

  assign in_fill   = (st == ST_FILL);
  assign in_wait   = (st == ST_WAIT);
  assign msg_ready = (st == ST_IDLE);
  assign accept    = msg_valid && msg_ready && !too_long;
  assign err_nospc = msg_valid && msg_ready && too_long;
  assign sel_full  = wr_video ? video_full : host_full;
  assign hdr_only  = in_fill && (len_q == '0);
  assign byte_ready = in_fill && (len_q != '0) && !sel_full;
  assign byte_fire = byte_valid && byte_ready;
  assign fill_end  = (byte_fire && pk_last) || (hdr_only && !sel_full);

  hcpw_packer #(.LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .load(accept), .vc(msg_vc), .dtype(msg_dtype),
    .len(len_q), .fire(byte_fire), .data(byte_data),
    .word(pk_word), .close(pk_close), .last(pk_last)
  );

  hcpw_txwait #(.TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .arm(in_wait), .tx_done(tx_done),
    .limit(tmo_cycles), .expire(expire)
  );

  assign wr_valid    = (byte_fire && pk_close) || (hdr_only && !sel_full);
  assign wr_data     = pk_word;
  assign done        = in_wait && tx_done;
  assign err_timeout = expire;
  assign done_count  = bta_req ? '0 : (CNT_W'(len_q) + CNT_W'(4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      len_q    <= '0;
      wr_video <= 1'b0;
      bta_req  <= 1'b0;
      hs_mode  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st       <= ST_FILL;
          len_q    <= msg_len;
          wr_video <= use_video;
          bta_req  <= want_bta;
          hs_mode  <= want_hs;
        end
        ST_FILL: if (fill_end) st <= ST_WAIT;
        ST_WAIT: if (done || err_timeout) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hcpw_checker.sv
module hcpw_checker (
  input logic clk,
  input logic rst_n,
  input logic msg_ready,
  input logic byte_ready,
  input logic host_full,
  input logic video_full,
  input logic wr_valid,
  input logic wr_video,
  input logic bta_req,
  input logic hs_mode,
  input logic done,
  input logic err_nospc,
  input logic err_timeout,
  input logic in_fill,
  input logic in_wait
);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !(wr_video ? video_full : host_full));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && (wr_video ? video_full : host_full)) |-> !byte_ready);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_timeout));

  assert_finish_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_timeout) |=> msg_ready);

  assert_refuse_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_nospc |=> (msg_ready && !wr_valid));

  assert_select_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && $past(in_fill)) |-> $stable(wr_video));

  assert_flags_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && $past(in_wait)) |-> ($stable(bta_req) && $stable(hs_mode)));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !msg_ready);
endmodule

bind host_cmd_packer hcpw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .msg_ready(msg_ready), .byte_ready(byte_ready),
  .host_full(host_full), .video_full(video_full), .wr_valid(wr_valid),
  .wr_video(wr_video), .bta_req(bta_req), .hs_mode(hs_mode), .done(done),
  .err_nospc(err_nospc), .err_timeout(err_timeout),
  .in_fill(in_fill), .in_wait(in_wait)
);

// File: tb/sim_host_cmd_packer.sv
`timescale 1ns/1ps
module sim_host_cmd_packer;
  localparam int LEN_W = 12;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0, msg_lp = 1'b0, msg_ack = 1'b0, msg_rd = 1'b0;
  logic [1:0] msg_vc = '0;
  logic [5:0] msg_dtype = '0;
  logic [LEN_W-1:0] msg_len = '0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic host_full = 1'b0, video_full = 1'b0, tx_done = 1'b0;
  logic [TMO_W-1:0] tmo_cycles = 16'd1000;
  logic msg_ready, byte_ready, wr_valid, wr_video, bta_req, hs_mode;
  logic done, err_nospc, err_timeout;
  logic [31:0] wr_data;
  logic [LEN_W:0] done_count;

  int n_chk = 0;
  int n_bad = 0;
  logic [33:0] exp_q[$];  // {is_header, video, word}

  always #4 clk = ~clk;

  host_cmd_packer u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vc(msg_vc), .msg_dtype(msg_dtype), .msg_lp(msg_lp), .msg_ack(msg_ack),
    .msg_rd(msg_rd), .msg_len(msg_len), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data), .host_full(host_full),
    .video_full(video_full), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_video(wr_video), .bta_req(bta_req), .hs_mode(hs_mode),
    .tx_done(tx_done), .tmo_cycles(tmo_cycles), .done(done),
    .done_count(done_count), .err_nospc(err_nospc), .err_timeout(err_timeout)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Monitor: compare every written word against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected word", wr_data, 0);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        if (e[33]) check(wr_data == e[31:0], "R1 header", wr_data, e[31:0]);
        else       check(wr_data == e[31:0], "R2 payload", wr_data, e[31:0]);
        check(wr_video == e[32], "R4 fifo select", wr_video, e[32]);
      end
    end
  end

  task automatic send(input logic [1:0] vc, input logic [5:0] dt, input logic lp,
                      input logic ack, input logic rd, input int len, input logic [7:0] seed,
                      input logic stall, input int tx_delay, input int tmo);
    logic [7:0] b[$];
    logic vid;
    logic [31:0] w;
    logic rdy;
    bit fin;
    vid = (len > 256);
    for (int k = 0; k < len; k++) b.push_back(8'(seed + 8'(k * 13)));
    w = {8'h00, (len > 1) ? b[1] : 8'h00, (len > 0) ? b[0] : 8'h00, vc, dt};
    exp_q.push_back({1'b1, vid, w});
    for (int p = 2; p < len; p += 4) begin
      w = '0;
      for (int i = 0; i < 4; i++) if (p + i < len) w[8*i +: 8] = b[p+i];
      exp_q.push_back({1'b0, vid, w});
    end
    tmo_cycles = 16'(tmo);
    msg_vc = vc; msg_dtype = dt; msg_lp = lp; msg_ack = ack; msg_rd = rd;
    msg_len = LEN_W'(len); msg_valid = 1'b1;
    @(negedge clk);
    check(msg_ready == 1'b1, "R10 ready when idle", msg_ready, 1);
    check(err_nospc == 1'b0, "R3 accepted length", err_nospc, 0);
    @(posedge clk); #1;
    msg_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      byte_valid = 1'b1;
      byte_data = b[k];
      if (stall && k == 3) begin
        host_full = 1'b1; video_full = 1'b1;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          check(byte_ready == 1'b0, "R8 stall on full", byte_ready, 0);
          @(posedge clk); #1;
        end
        host_full = 1'b0; video_full = 1'b0;
      end
      do begin
        @(negedge clk);
        rdy = byte_ready;
        @(posedge clk); #1;
      end while (!rdy);
    end
    byte_valid = 1'b0;
    if (len == 0) begin
      @(negedge clk);
      @(posedge clk); #1;
    end
    check(exp_q.size() == 0, "R2 word count", exp_q.size(), 0);
    check(msg_ready == 1'b0, "R10 busy", msg_ready, 0);
    check(bta_req == (ack | rd), "R5 turnaround", bta_req, ack | rd);
    check(hs_mode == !lp, "R6 high speed", hs_mode, !lp);
    fin = 0;
    for (int c = 0; !fin; c++) begin
      tx_done = (c == tx_delay);
      @(negedge clk);
      if (tx_done) begin
        check(done == 1'b1, "R7 done pulse", done, 1);
        check(done_count == ((ack | rd) ? 0 : 4 + len), "R7 count", done_count, (ack | rd) ? 0 : 4 + len);
        check(err_timeout == 1'b0, "R9 completion wins", err_timeout, 0);
        fin = 1;
      end else if (c == tmo - 1) begin
        check(err_timeout == 1'b1, "R9 timeout", err_timeout, 1);
        fin = 1;
      end else if (done || err_timeout) begin
        check(1'b0, "R9 early end", {done, err_timeout}, 0);
        fin = 1;
      end
      @(posedge clk); #1;
      tx_done = 1'b0;
    end
    check(msg_ready == 1'b1, "R10 idle after end", msg_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(msg_ready == 1'b1, "R10 reset ready", msg_ready, 1);
    check(wr_valid == 1'b0, "R2 reset no write", wr_valid, 0);
    check(done == 1'b0 && err_timeout == 1'b0, "R9 reset quiet", done, 0);
    @(posedge clk); #1;

    send(2'd2, 6'h05, 0, 0, 0, 0,    8'h11, 0, 2,  100);  // R1 header only
    send(2'd1, 6'h29, 0, 0, 0, 1,    8'hA0, 0, 0,  100);  // R1 one byte
    send(2'd3, 6'h39, 0, 1, 0, 2,    8'h5C, 0, 3,  100);  // R5 R7 ack
    send(2'd0, 6'h39, 1, 0, 0, 7,    8'h01, 1, 1,  100);  // R6 R8 stall
    send(2'd1, 6'h14, 0, 0, 1, 10,   8'hF0, 0, 5,  100);  // R5 read
    send(2'd0, 6'h39, 0, 0, 0, 256,  8'h33, 0, 0,  100);  // R4 host edge
    send(2'd2, 6'h39, 0, 0, 0, 257,  8'h77, 1, 2,  100);  // R4 video
    send(2'd0, 6'h39, 0, 0, 0, 1920, 8'h09, 0, 1,  100);  // R3 limit accepted

    // R3 refused length
    msg_len = LEN_W'(1921); msg_valid = 1'b1;
    @(negedge clk);
    check(err_nospc == 1'b1, "R3 refuse", err_nospc, 1);
    @(posedge clk); #1;
    msg_valid = 1'b0;
    @(negedge clk);
    check(msg_ready == 1'b1 && wr_valid == 1'b0, "R3 stays idle", msg_ready, 1);
    @(posedge clk); #1;

    send(2'd1, 6'h39, 0, 0, 0, 3, 8'h42, 0, 100, 5);  // R9 expiry
    send(2'd1, 6'h39, 0, 0, 0, 3, 8'h43, 0, 4,   5);  // R9 same-cycle race
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule